// File: doc/BRIEF.md
# Edge-Selectable Interrupt Status Aggregator

This block gathers sixteen interrupt sources of a line-interface device into one interrupt output. Eight sources are live level signals (signal loss, alarm indication, driver fault, transmit clock loss, test-pattern sync, the two loopback code detectors and equalizer range). A per-source edge select decides whether a rising or a falling transition of each level latches its sticky status bit. The other eight sources are one-cycle event pulses: pattern error, code violation, excess zeros, jitter FIFO overflow and underflow, one-second tick, counter overflow and waveform DAC overflow. Each pulse latches its status bit directly.

Every status bit has its own enable in a mask register. Any pending enabled bit makes the interrupt output active. A host reads a status register through a small synchronous register bus, and that read clears the register. A two-bit pin mode field selects open-drain active-low, push-pull active-low or push-pull active-high signalling. Open-drain is modelled as an output enable with a data value that is held low.

Top module: `irq_aggregator`

## Requirements
- R1: After reset all enables are 0, all status bits are 0, all edge selects are 0 and the pin mode is 00. With nothing pending, `int_oe` and `int_o` are both 0.
- R2: With edge select bit i at 0, a 0-to-1 change on `lvl_i[i]` sets bit i of the level status register (address 19h). The bit is set on the clock edge that first samples the new level. A 1-to-0 change is ignored.
- R3: With edge select bit i at 1 (register 16h), a 1-to-0 change on `lvl_i[i]` sets bit i of register 19h. A 0-to-1 change is ignored.
- R4: A one-cycle pulse on `evt_i[i]` sets bit i of the event status register (address 1Ah).
- R5: Enable registers 14h (level group) and 15h (event group) gate each status bit, with 1 meaning enabled. A pending bit whose enable is 0 does not activate the output. Setting its enable later makes the output active.
- R6: A read of 19h or 1Ah returns the status value held before the read and clears that register. The output goes inactive when no other enabled bit is pending.
- R7: A source that sets a status bit in the same cycle as the read of its register keeps that bit set. The next read returns it.
- R8: A read of 17h returns the value on `lvl_i` at the clock edge of the read. A read of 18h returns 0.
- R9: Pin mode field (register 02h, bits 1:0). 00: `int_oe`=1 only when an enabled bit is pending, and `int_o`=0. 01 and 11: `int_oe`=1 always, and `int_o`=0 when pending, else 1. 10: `int_oe`=1 always, and `int_o`=1 when pending, else 0.
- R10: Registers 02h, 14h, 15h and 16h read back what was written (02h bits 7:2 read 0). Unmapped addresses read 0 and ignore writes. Read data is registered one edge after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lvl_i | input | 8 | Live level status sources |
| evt_i | input | 8 | One-cycle event pulse sources |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| int_o | output | 1 | Interrupt pin data value |
| int_oe | output | 1 | Interrupt pin output enable |

## Verification
A level change or event pulse that is present at clock edge N shows in the status register and on the pins right after edge N. No further register sits between the status flops and the pins. A register write takes effect after its own edge. Read data appears after the read's edge and is sampled before the next edge. The bench drives each vector on a falling edge and samples every result on the following falling edge. Each check therefore lands exactly one rising edge after its stimulus.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam logic [7:0] ADR_CFG  = 8'h02;
  localparam logic [7:0] ADR_MSK0 = 8'h14;
  localparam logic [7:0] ADR_MSK1 = 8'h15;
  localparam logic [7:0] ADR_ESEL = 8'h16;
  localparam logic [7:0] ADR_LIV0 = 8'h17;
  localparam logic [7:0] ADR_LIV1 = 8'h18;
  localparam logic [7:0] ADR_STS0 = 8'h19;
  localparam logic [7:0] ADR_STS1 = 8'h1A;

  typedef enum logic [1:0] {
    PIN_OD_LOW  = 2'b00,
    PIN_PP_LOW  = 2'b01,
    PIN_PP_HIGH = 2'b10,
    PIN_PP_LOW2 = 2'b11
  } pin_mode_e;
endpackage

// File: rtl/irq_lvl_edge.sv
module irq_lvl_edge #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] esel_i,
  output logic [W-1:0] set_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] prev_d;

  always_comb prev_d = lvl_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  // esel = 0 selects rising, 1 selects falling
  for (genvar i = 0; i < W; i++) begin : g_edge
    logic rise, fall;
    assign rise     = lvl_i[i] & ~prev_q[i];
    assign fall     = ~lvl_i[i] & prev_q[i];
    assign set_o[i] = esel_i[i] ? fall : rise;
  end
endmodule

// File: rtl/irq_sticky.sv
module irq_sticky #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] sts_o
);
  logic [W-1:0] sts_q;
  logic [W-1:0] sts_d;

  // a set arriving with the clear wins
  always_comb sts_d = (clr_i ? '0 : sts_q) | set_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= sts_d;
  end

  assign sts_o = sts_q;

  for (genvar i = 0; i < W; i++) begin : g_chk
    assert_set_sticky_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> sts_o[i]);
    assert_clear_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i[i]) |=> !sts_o[i]);
    assert_keep_on_read_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && set_i[i]) |=> sts_o[i]);
    assert_hold_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && sts_o[i]) |=> sts_o[i]);
  end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] sts0_i,
  input  logic [DW-1:0] sts1_i,
  input  logic [DW-1:0] live_i,
  output logic [DW-1:0] bus_rdata,
  output pin_mode_e     mode_o,
  output logic [DW-1:0] msk0_o,
  output logic [DW-1:0] msk1_o,
  output logic [DW-1:0] esel_o,
  output logic          clr0_o,
  output logic          clr1_o
);
  localparam int MW = 2;

  logic          wr_en, rd_en;
  logic [MW-1:0] mode_q, mode_d;
  logic [DW-1:0] msk0_q, msk0_d, msk1_q, msk1_d, esel_q, esel_d;
  logic [DW-1:0] rdat_q, rdat_d;

  assign wr_en = bus_sel & bus_wr;
  assign rd_en = bus_sel & ~bus_wr;

  always_comb begin
    mode_d = mode_q;
    msk0_d = msk0_q;
    msk1_d = msk1_q;
    esel_d = esel_q;
    if (wr_en) begin
      case (bus_addr)
        AW'(ADR_CFG):  mode_d = bus_wdata[MW-1:0];
        AW'(ADR_MSK0): msk0_d = bus_wdata;
        AW'(ADR_MSK1): msk1_d = bus_wdata;
        AW'(ADR_ESEL): esel_d = bus_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdat_d = rdat_q;
    if (rd_en) begin
      case (bus_addr)
        AW'(ADR_CFG):  rdat_d = DW'(mode_q);
        AW'(ADR_MSK0): rdat_d = msk0_q;
        AW'(ADR_MSK1): rdat_d = msk1_q;
        AW'(ADR_ESEL): rdat_d = esel_q;
        AW'(ADR_LIV0): rdat_d = live_i;
        AW'(ADR_LIV1): rdat_d = '0;
        AW'(ADR_STS0): rdat_d = sts0_i;
        AW'(ADR_STS1): rdat_d = sts1_i;
        default:       rdat_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      msk0_q <= '0;
      msk1_q <= '0;
      esel_q <= '0;
      rdat_q <= '0;
    end else begin
      mode_q <= mode_d;
      msk0_q <= msk0_d;
      msk1_q <= msk1_d;
      esel_q <= esel_d;
      rdat_q <= rdat_d;
    end
  end

  assign clr0_o    = rd_en && (bus_addr == AW'(ADR_STS0));
  assign clr1_o    = rd_en && (bus_addr == AW'(ADR_STS1));
  assign mode_o    = pin_mode_e'(mode_q);
  assign msk0_o    = msk0_q;
  assign msk1_o    = msk1_q;
  assign esel_o    = esel_q;
  assign bus_rdata = rdat_q;

  assert_mask_hold_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && bus_addr == AW'(ADR_MSK0)) |=> $stable(msk0_o));
  assert_rdata_hold_R10 : assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(bus_rdata));
  assert_one_clear_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    !(clr0_o && clr1_o));
endmodule

// File: rtl/irq_pin.sv
module irq_pin
  import irq_pkg::*;
(
  input  pin_mode_e mode_i,
  input  logic      pend_i,
  output logic      int_o,
  output logic      int_oe
);
  always_comb begin
    case (mode_i)
      PIN_OD_LOW: begin
        int_oe = pend_i;
        int_o  = 1'b0;
      end
      PIN_PP_HIGH: begin
        int_oe = 1'b1;
        int_o  = pend_i;
      end
      default: begin
        int_oe = 1'b1;
        int_o  = ~pend_i;
      end
    endcase
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] lvl_i,
  input  logic [DW-1:0] evt_i,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          int_o,
  output logic          int_oe
);
  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] rsync_q;
  logic              rst_s_n;
  logic [DW-1:0]     lvl_set, sts0, sts1, msk0, msk1, esel;
  logic              clr0, clr1, pend;
  pin_mode_e         mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_s_n = rsync_q[SYNC_N-1];

  irq_lvl_edge #(.W(DW)) u_edge (
    .clk(clk), .rst_n(rst_s_n), .lvl_i(lvl_i), .esel_i(esel), .set_o(lvl_set));

  irq_sticky #(.W(DW)) u_sts_lvl (
    .clk(clk), .rst_n(rst_s_n), .set_i(lvl_set), .clr_i(clr0), .sts_o(sts0));

  irq_sticky #(.W(DW)) u_sts_evt (
    .clk(clk), .rst_n(rst_s_n), .set_i(evt_i), .clr_i(clr1), .sts_o(sts1));

  irq_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_s_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .sts0_i(sts0), .sts1_i(sts1),
    .live_i(lvl_i), .bus_rdata(bus_rdata), .mode_o(mode), .msk0_o(msk0),
    .msk1_o(msk1), .esel_o(esel), .clr0_o(clr0), .clr1_o(clr1));

  assign pend = |((sts0 & msk0) | (sts1 & msk1));

  irq_pin u_pin (.mode_i(mode), .pend_i(pend), .int_o(int_o), .int_oe(int_oe));

  assert_od_never_high_R9 : assert property (@(posedge clk) disable iff (!rst_s_n)
    (mode == PIN_OD_LOW) |-> !int_o);
  assert_masked_quiet_R5 : assert property (@(posedge clk) disable iff (!rst_s_n)
    (((sts0 & msk0) == '0) && ((sts1 & msk1) == '0) && mode == PIN_OD_LOW) |-> !int_oe);
  assert_pushpull_drives_R9 : assert property (@(posedge clk) disable iff (!rst_s_n)
    (mode != PIN_OD_LOW) |-> int_oe);
endmodule

// File: tb/irq_aggregator_bench.sv
module irq_aggregator_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 30;

  typedef struct packed {
    logic [1:0] op;    // 0 idle, 1 write, 2 read-and-compare
    logic [7:0] addr;
    logic [7:0] wdata;
    logic [7:0] lvl;
    logic [7:0] evt;
    logic [7:0] exp;
    logic [1:0] pin;   // expected {int_oe, int_o}
    logic [3:0] req;
  } vec_t;

  localparam vec_t TBL [NV] = '{
    '{2'd0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 2'b00, 4'd1},  // R1 idle
    '{2'd1, 8'h14, 8'h0F, 8'h00, 8'h00, 8'h00, 2'b00, 4'd5},  // R5 enable level 0..3
    '{2'd1, 8'h15, 8'hFF, 8'h00, 8'h00, 8'h00, 2'b00, 4'd5},  // R5 enable events
    '{2'd0, 8'h00, 8'h00, 8'h01, 8'h00, 8'h00, 2'b10, 4'd2},  // R2 rising bit0
    '{2'd2, 8'h19, 8'h00, 8'h01, 8'h00, 8'h01, 2'b00, 4'd6},  // R6 read clears
    '{2'd0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 2'b00, 4'd2},  // R2 fall ignored
    '{2'd1, 8'h16, 8'h02, 8'h00, 8'h00, 8'h00, 2'b00, 4'd3},  // R3 bit1 falling
    '{2'd0, 8'h00, 8'h00, 8'h02, 8'h00, 8'h00, 2'b00, 4'd3},  // R3 rise ignored
    '{2'd0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 2'b10, 4'd3},  // R3 fall sets
    '{2'd2, 8'h19, 8'h00, 8'h00, 8'h00, 8'h02, 2'b00, 4'd3},  // R3 readback
    '{2'd1, 8'h02, 8'h01, 8'h00, 8'h00, 8'h00, 2'b11, 4'd9},  // R9 pp low idle
    '{2'd0, 8'h00, 8'h00, 8'h00, 8'h10, 8'h00, 2'b10, 4'd4},  // R4 event bit4
    '{2'd2, 8'h1A, 8'h00, 8'h00, 8'h20, 8'h10, 2'b10, 4'd7},  // R7 event during read
    '{2'd2, 8'h1A, 8'h00, 8'h00, 8'h00, 8'h20, 2'b11, 4'd7},  // R7 kept bit
    '{2'd1, 8'h15, 8'h00, 8'h00, 8'h00, 8'h00, 2'b11, 4'd5},
    '{2'd0, 8'h00, 8'h00, 8'h00, 8'h01, 8'h00, 2'b11, 4'd5},  // R5 masked event
    '{2'd2, 8'h15, 8'h00, 8'h00, 8'h00, 8'h00, 2'b11, 4'd10}, // R10 readback
    '{2'd1, 8'h15, 8'h01, 8'h00, 8'h00, 8'h00, 2'b10, 4'd5},  // R5 unmask exposes
    '{2'd1, 8'h02, 8'h02, 8'h00, 8'h00, 8'h00, 2'b11, 4'd9},  // R9 pp high
    '{2'd2, 8'h1A, 8'h00, 8'h00, 8'h00, 8'h01, 2'b10, 4'd9},  // R9 pp high idle
    '{2'd1, 8'h02, 8'h03, 8'h00, 8'h00, 8'h00, 2'b11, 4'd9},  // R9 mode 11
    '{2'd2, 8'h02, 8'h00, 8'h00, 8'h00, 8'h03, 2'b11, 4'd10},
    '{2'd0, 8'h00, 8'h00, 8'h80, 8'h00, 8'h00, 2'b11, 4'd5},  // R5 masked level
    '{2'd2, 8'h19, 8'h00, 8'h80, 8'h00, 8'h80, 2'b11, 4'd2},
    '{2'd2, 8'h17, 8'h00, 8'h80, 8'h00, 8'h80, 2'b11, 4'd8},  // R8 live
    '{2'd2, 8'h18, 8'h00, 8'h80, 8'h00, 8'h00, 2'b11, 4'd8},  // R8 upper live
    '{2'd1, 8'h30, 8'hFF, 8'h80, 8'h00, 8'h00, 2'b11, 4'd10},
    '{2'd2, 8'h30, 8'h00, 8'h80, 8'h00, 8'h00, 2'b11, 4'd10}, // R10 unmapped
    '{2'd2, 8'h16, 8'h00, 8'h80, 8'h00, 8'h02, 2'b11, 4'd10},
    '{2'd2, 8'h14, 8'h00, 8'h80, 8'h00, 8'h0F, 2'b11, 4'd10}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] lvl_i, evt_i, bus_addr, bus_wdata, bus_rdata;
  logic       bus_sel, bus_wr, int_o, int_oe;
  int         checks = 0;
  int         errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_aggregator u_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .lvl_i(lvl_i), .evt_i(evt_i),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .int_o(int_o), .int_oe(int_oe));

  task automatic chk(input int req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(input vec_t v);
    lvl_i     = v.lvl;
    evt_i     = v.evt;
    bus_sel   = (v.op != 2'd0);
    bus_wr    = (v.op == 2'd1);
    bus_addr  = v.addr;
    bus_wdata = v.wdata;
    @(posedge clk);
    @(negedge clk);
    evt_i   = '0;
    bus_sel = 1'b0;
    if (v.op == 2'd2) chk(int'(v.req), "rdata", bus_rdata, v.exp);
    chk(int'(v.req), "pins", {6'd0, int_oe, int_o}, {6'd0, v.pin});
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    lvl_i = '0; evt_i = '0; bus_sel = 1'b0; bus_wr = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    do_reset();
    // R1: reset state at the pins and read data
    chk(1, "reset pins", {6'd0, int_oe, int_o}, 8'h00);
    chk(1, "reset rdata", bus_rdata, 8'h00);
    for (int k = 0; k < NV; k++) step(TBL[k]);

    // R1: mid-run reset restores defaults
    do_reset();
    chk(1, "pins after reset", {6'd0, int_oe, int_o}, 8'h00);
    step('{2'd2, 8'h14, 8'h00, 8'h80, 8'h00, 8'h00, 2'b00, 4'd1});
    step('{2'd2, 8'h16, 8'h00, 8'h80, 8'h00, 8'h00, 2'b00, 4'd1});
    step('{2'd2, 8'h02, 8'h00, 8'h80, 8'h00, 8'h00, 2'b00, 4'd1});
    // R6: reading one group keeps output active for the other group
    step('{2'd1, 8'h14, 8'h01, 8'h80, 8'h00, 8'h00, 2'b00, 4'd6});
    step('{2'd1, 8'h15, 8'h01, 8'h80, 8'h00, 8'h00, 2'b00, 4'd6});
    step('{2'd0, 8'h00, 8'h00, 8'h81, 8'h01, 8'h00, 2'b10, 4'd6});
    step('{2'd2, 8'h19, 8'h00, 8'h81, 8'h00, 8'h81, 2'b10, 4'd6});
    step('{2'd2, 8'h1A, 8'h00, 8'h81, 8'h00, 8'h01, 2'b00, 4'd6});
    // R7: level edge landing on its own read survives
    step('{2'd2, 8'h19, 8'h00, 8'h80, 8'h00, 8'h00, 2'b00, 4'd7});
    step('{2'd1, 8'h16, 8'h01, 8'h80, 8'h00, 8'h00, 2'b00, 4'd7});
    step('{2'd2, 8'h19, 8'h00, 8'h00, 8'h00, 8'h00, 2'b00, 4'd7});
    step('{2'd2, 8'h19, 8'h00, 8'h00, 8'h00, 8'h00, 2'b00, 4'd7});
    step('{2'd0, 8'h00, 8'h00, 8'h01, 8'h00, 8'h00, 2'b00, 4'd7});
    step('{2'd2, 8'h19, 8'h00, 8'h00, 8'h00, 8'h00, 2'b10, 4'd7});
    step('{2'd2, 8'h19, 8'h00, 8'h00, 8'h00, 8'h01, 2'b00, 4'd7});

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule